// File: doc/BRIEF.md
# Speculative Load Tracking Bit Array

This block sits beside a 32 KB, four-way, 64-byte-line data cache. It keeps one small group of "loaded while speculative" flags for each of the 512 lines, with one flag per speculative checkpoint. When a load that belongs to checkpoint c retires ahead of program order, flag c of the line it read is set.

If that line later leaves the cache, the checkpoint can no longer prove that the load saw a value consistent with total store ordering, so the block asks for that checkpoint to be failed. A line can leave through a coherence invalidation or through a local eviction. When a checkpoint commits or is abandoned, its flag is wiped in every line at once.

The pipeline drives retire, line-loss and checkpoint-release events into the block. It reacts to the returned one-cycle fail pulses, which come as a vector indexed by checkpoint number. The block needs no associative search: each event touches either one addressed line or one flag column.

Top module: `spec_load_track`

## Requirements
- R1: After reset every flag is clear and `failReq` is all zeros.
- R2: A retire event for checkpoint c on line L sets flag c of L. A later loss of L (invalidation or eviction) drives `failReq[c]` high in the cycle after the loss edge, for exactly one cycle. Bit c of `failReq` belongs to checkpoint c.
- R3: A loss of a line whose flags are all clear raises no fail request. A loss of line L never reports flags held by a different line.
- R4: A set bit c in `commitMask` or in `abortMask` clears flag c in every line. Flags of other checkpoints are unaffected.
- R5: If a lost line holds flags for several checkpoints, all of their fail bits rise in the same cycle.
- R6: A release of checkpoint c and a retire for checkpoint c in the same cycle apply the release first, so the new flag is kept.
- R7: A loss clears all flags of the lost line. A second loss of that line raises no fail request.
- R8: A retire to line L in the same cycle as a loss of L is reported as a fail of that checkpoint, and the flag is not kept.
- R9: A loss in the same cycle as a release of checkpoint c reports no fail for c.
- R10: An invalidation and an eviction of two different lines in the same cycle report the OR of both lines' flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| retireValid | input | 1 | A speculative load retires this cycle |
| retireLine | input | 9 | Line index read by the retiring load |
| retireCkpt | input | 1 | Checkpoint owning the retiring load |
| snoopInvValid | input | 1 | A coherence invalidation removes a line |
| snoopInvLine | input | 9 | Index of the invalidated line |
| evictValid | input | 1 | A local victim leaves the cache |
| evictLine | input | 9 | Index of the evicted line |
| commitMask | input | 2 | Checkpoints committing this cycle |
| abortMask | input | 2 | Checkpoints failing this cycle |
| failReq | output | 2 | One-cycle fail request per checkpoint |

## Verification
Every event is captured at one clock edge. The only visible result is `failReq`, which is due in the cycle right after the edge that captured a loss, and it must be zero again one cycle later. The driver gives each stimulus cycle one expected `failReq` value, tagged with the cycle count that follows, and this includes the all-zero value for cycles without a loss. The monitor compares at the falling edge of that cycle only. This also catches pulses that stay high too long or that appear early. Flag state that a release or a loss should have removed is observed by losing the same line again and expecting zero.

// File: rtl/slt_pkg.sv
package slt_pkg;
  parameter int unsigned CACHE_BYTES = 32768;
  parameter int unsigned LINE_BYTES  = 64;
  parameter int unsigned NUM_CKPTS   = 2;

  localparam int unsigned NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int unsigned LINE_W    = $clog2(NUM_LINES);
  localparam int unsigned CKPT_W    = (NUM_CKPTS > 1) ? $clog2(NUM_CKPTS) : 1;

  typedef logic [LINE_W-1:0]    lineIdx_t;
  typedef logic [NUM_CKPTS-1:0] ckptVec_t;

  // strobes from control to the flag array
  typedef struct packed {
    logic     setEn;
    lineIdx_t setLine;
    ckptVec_t setMask;
    ckptVec_t clrMask;
    logic     lossAEn;
    lineIdx_t lossALine;
    logic     lossBEn;
    lineIdx_t lossBLine;
  } sltStrobe_t;
endpackage

// File: rtl/slt_bitarray.sv
module slt_bitarray
  import slt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sltStrobe_t strb,
  output ckptVec_t   rdA,
  output ckptVec_t   rdB
);
  logic [NUM_LINES-1:0][NUM_CKPTS-1:0] bits;
  logic [NUM_LINES-1:0][NUM_CKPTS-1:0] nxtBits;
  ckptVec_t setMaskEff;
  ckptVec_t colAny;

  assign setMaskEff = strb.setEn ? strb.setMask : '0;

  // per line: column release, then new set, then line loss wipes everything
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic setHit;
    logic lossHit;
    assign setHit  = strb.setEn && (strb.setLine == lineIdx_t'(g));
    assign lossHit = (strb.lossAEn && (strb.lossALine == lineIdx_t'(g))) ||
                     (strb.lossBEn && (strb.lossBLine == lineIdx_t'(g)));
    assign nxtBits[g] = lossHit ? '0 :
                        ((bits[g] & ~strb.clrMask) | (setHit ? strb.setMask : '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bits <= '0;
    else       bits <= nxtBits;
  end

  assign rdA = bits[strb.lossALine];
  assign rdB = bits[strb.lossBLine];

  always_comb begin
    colAny = '0;
    for (int i = 0; i < NUM_LINES; i++) colAny |= bits[i];
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setEn &&
     !(strb.lossAEn && strb.lossALine == strb.setLine) &&
     !(strb.lossBEn && strb.lossBLine == strb.setLine))
    |=> ((bits[$past(strb.setLine)] & $past(strb.setMask)) == $past(strb.setMask)));

  // R4
  clr_column_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.clrMask) |=> ((colAny & $past(strb.clrMask & ~setMaskEff)) == '0));

  // R7
  loss_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lossAEn |=> (bits[$past(strb.lossALine)] == '0));
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [LINE_W-1:0] retireLine,
  input  logic [CKPT_W-1:0] retireCkpt,
  input  logic              snoopInvValid,
  input  logic [LINE_W-1:0] snoopInvLine,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  input  ckptVec_t          commitMask,
  input  ckptVec_t          abortMask,
  input  ckptVec_t          rdA,
  input  ckptVec_t          rdB,
  output sltStrobe_t        strb,
  output ckptVec_t          failReq
);
  ckptVec_t retireOh;
  ckptVec_t hitA;
  ckptVec_t hitB;
  ckptVec_t failNxt;

  assign retireOh = ckptVec_t'(1) << retireCkpt;

  always_comb begin
    strb.setEn     = retireValid;
    strb.setLine   = retireLine;
    strb.setMask   = retireOh;
    strb.clrMask   = commitMask | abortMask;
    strb.lossAEn   = snoopInvValid;
    strb.lossALine = snoopInvLine;
    strb.lossBEn   = evictValid;
    strb.lossBLine = evictLine;
  end

  // stored flags of released checkpoints no longer count; a same-cycle
  // retire to the lost line does count
  always_comb begin
    hitA = '0;
    hitB = '0;
    if (snoopInvValid)
      hitA = (rdA & ~strb.clrMask) |
             ((retireValid && retireLine == snoopInvLine) ? retireOh : '0);
    if (evictValid)
      hitB = (rdB & ~strb.clrMask) |
             ((retireValid && retireLine == evictLine) ? retireOh : '0);
    failNxt = hitA | hitB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) failReq <= '0;
    else       failReq <= failNxt;
  end

  // R3
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|failReq) |-> $past(snoopInvValid || evictValid));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (failReq == '0));
endmodule

// File: rtl/spec_load_track.sv
module spec_load_track
  import slt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 retireValid,
  input  logic [LINE_W-1:0]    retireLine,
  input  logic [CKPT_W-1:0]    retireCkpt,
  input  logic                 snoopInvValid,
  input  logic [LINE_W-1:0]    snoopInvLine,
  input  logic                 evictValid,
  input  logic [LINE_W-1:0]    evictLine,
  input  logic [NUM_CKPTS-1:0] commitMask,
  input  logic [NUM_CKPTS-1:0] abortMask,
  output logic [NUM_CKPTS-1:0] failReq
);
  sltStrobe_t strb;
  ckptVec_t   rdA;
  ckptVec_t   rdB;

  slt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .retireValid(retireValid), .retireLine(retireLine), .retireCkpt(retireCkpt),
    .snoopInvValid(snoopInvValid), .snoopInvLine(snoopInvLine),
    .evictValid(evictValid), .evictLine(evictLine),
    .commitMask(commitMask), .abortMask(abortMask),
    .rdA(rdA), .rdB(rdB), .strb(strb), .failReq(failReq)
  );

  slt_bitarray u_array (
    .clk(clk), .rstN(rstN), .strb(strb), .rdA(rdA), .rdB(rdB)
  );
endmodule

// File: tb/spec_load_track_bench.sv
`timescale 1ns/1ps
module spec_load_track_bench;
  import slt_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retireValid = 1'b0;
  logic [LINE_W-1:0] retireLine = '0;
  logic [CKPT_W-1:0] retireCkpt = '0;
  logic snoopInvValid = 1'b0;
  logic [LINE_W-1:0] snoopInvLine = '0;
  logic evictValid = 1'b0;
  logic [LINE_W-1:0] evictLine = '0;
  logic [NUM_CKPTS-1:0] commitMask = '0;
  logic [NUM_CKPTS-1:0] abortMask = '0;
  logic [NUM_CKPTS-1:0] failReq;

  spec_load_track u_spec_load_track (.*);

  always #5 clk = ~clk;

  typedef struct {
    int        due;
    logic [NUM_CKPTS-1:0] exp;
    string     tag;
  } expItem_t;

  expItem_t sbq[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the due expectation at the falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      expItem_t it;
      it = sbq.pop_front();
      nChecks++;
      if (failReq !== it.exp) begin
        nFails++;
        $display("FAIL %s: failReq=%b expected=%b (cycle %0d)", it.tag, failReq, it.exp, cyc);
      end
    end
  end

  // driver: inputs already set for this cycle; record expected result, advance
  task automatic tick(input logic [NUM_CKPTS-1:0] exp, input string tag);
    expItem_t it;
    it.due = cyc + 1;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    #1;
    retireValid = 0; snoopInvValid = 0; evictValid = 0;
    commitMask = '0; abortMask = '0;
  endtask

  task automatic retire(input int line, input int ck);
    retireValid = 1; retireLine = LINE_W'(line); retireCkpt = CKPT_W'(ck);
  endtask
  task automatic inv(input int line);
    snoopInvValid = 1; snoopInvLine = LINE_W'(line);
  endtask
  task automatic evict(input int line);
    evictValid = 1; evictLine = LINE_W'(line);
  endtask

  initial begin
    #200_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    nChecks++;
    if (failReq !== 2'b00) begin
      nFails++;
      $display("FAIL R1: failReq=%b expected=00", failReq);
    end
    @(posedge clk); #1;

    // R1: loss right after reset finds nothing
    inv(3);                 tick(2'b00, "R1 clean after reset");
    // R2: set then loss, one-cycle pulse
    retire(5, 0);           tick(2'b00, "R2 set quiet");
    inv(5);                 tick(2'b01, "R2 loss fails ckpt0");
    tick(2'b00, "R2 pulse one cycle");
    // R3: other lines and empty lines
    retire(7, 1);           tick(2'b00, "R3 set");
    evict(8);               tick(2'b00, "R3 neighbour line");
    evict(9);               tick(2'b00, "R3 empty line");
    inv(7);                 tick(2'b10, "R3 owner line");
    // R5: several checkpoints on one line
    retire(20, 0);          tick(2'b00, "R5 set0");
    retire(20, 1);          tick(2'b00, "R5 set1");
    evict(20);              tick(2'b11, "R5 both fail");
    // R4: release clears the column only
    retire(30, 0);          tick(2'b00, "R4 set");
    retire(31, 1);          tick(2'b00, "R4 set");
    retire(32, 0);          tick(2'b00, "R4 set");
    commitMask = 2'b01;     tick(2'b00, "R4 commit0");
    inv(30);                tick(2'b00, "R4 line30 cleared");
    inv(31);                tick(2'b10, "R4 ckpt1 kept");
    inv(32);                tick(2'b00, "R4 line32 cleared");
    retire(40, 1);          tick(2'b00, "R4 set");
    abortMask = 2'b10;      tick(2'b00, "R4 abort1");
    evict(40);              tick(2'b00, "R4 abort clears");
    // R6: release and set same ckpt same cycle
    retire(50, 0); commitMask = 2'b01; tick(2'b00, "R6 set with clear");
    inv(50);                tick(2'b01, "R6 set survives");
    // R7: loss wipes the line
    retire(60, 1);          tick(2'b00, "R7 set");
    inv(60);                tick(2'b10, "R7 first loss");
    inv(60);                tick(2'b00, "R7 second loss");
    // R8: set and loss same line same cycle
    retire(70, 0); inv(70); tick(2'b01, "R8 same-cycle fail");
    inv(70);                tick(2'b00, "R8 flag not kept");
    // R9: loss with release
    retire(80, 0);          tick(2'b00, "R9 set");
    retire(80, 1);          tick(2'b00, "R9 set");
    inv(80); commitMask = 2'b01; tick(2'b10, "R9 released ckpt masked");
    // R10: both loss ports at once
    retire(90, 0);          tick(2'b00, "R10 set");
    retire(100, 1);         tick(2'b00, "R10 set");
    inv(90); evict(100);    tick(2'b11, "R10 or of both");
    // boundary lines
    retire(NUM_LINES-1, 1); tick(2'b00, "R2 top line set");
    inv(0);                 tick(2'b00, "R3 line0 empty");
    evict(NUM_LINES-1);     tick(2'b10, "R2 top line loss");
    tick(2'b00, "R2 idle");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule